// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt requests from three kinds of source and decides which of them, if any, goes to the processor. There is one non-maskable input, one debug-break input, and a parameterized set of programmable sources, external or peripheral. Software gives each programmable source a 4-bit level through a small register bus. The debug source has a fixed level. The non-maskable source sits at level 16, one step above anything software can program.

In every cycle with no request outstanding, the controller takes the highest pending level. It compares that level with the 4-bit mask the processor supplies from its status register. A maskable winner goes out only if its level is strictly above the mask. The non-maskable source always goes out.

The winner's level, source ID and vector number are registered and held on the request outputs until the processor pulses acknowledge. On that pulse the controller drops the request and loads the new mask value: the accepted level, or 4'hF for the non-maskable source. Arbitration starts again in the cycle after the acknowledge.

Top module: `prio_intc`

## Requirements
- R1: After reset, `irq_req` is 0, `mask_out` is 4'hF, and every priority register reads back as 0.
- R2: Priority register k holds four level fields. Bits [4j+3:4j] set the level of programmable source 4k+j. A write with `reg_we` high is visible one clock later. `reg_rdata` shows the register selected by `reg_addr` combinationally.
- R3: A maskable winner is presented only when its level is strictly greater than `sr_mask`. A source whose level is 0 is never presented.
- R4: Among pending programmable sources the highest level wins. Sources with equal levels go to the lowest index.
- R5: The debug source has level 15. It wins over any programmable source, including one at level 15, and is masked when `sr_mask` is 15.
- R6: A rising edge on `nmi_in` is latched and presented at level 16. It is presented whatever `sr_mask` holds, and it wins over all other sources. It stays pending until acknowledged. Holding `nmi_in` high does not cause a second request.
- R7: While `irq_req` is high and `ack` is low, `irq_level`, `irq_src` and `irq_vec` hold their values, whatever the request and mask inputs do.
- R8: When `ack` is high while `irq_req` is high, `irq_req` is 0 on the next clock. On that same clock `mask_out` takes the accepted level, or 4'hF for the non-maskable source. `mask_out` changes at no other time.
- R9: The source ID is 0 for the non-maskable source, 1 for debug and 2+i for programmable source i. The vector is `VEC_NMI` (11), `VEC_DBG` (12) or `VEC_BASE`+i (64+i), respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_in | input | 1 | Non-maskable request, edge-sensitive |
| dbg_req | input | 1 | Debug-break request, level-sensitive |
| src_req | input | NUM_SRC | Programmable source requests, level-sensitive |
| sr_mask | input | 4 | Current mask value from the processor status register |
| reg_we | input | 1 | Priority register write enable |
| reg_addr | input | ADDR_W | Priority register index |
| reg_wdata | input | 16 | Priority register write data |
| reg_rdata | output | 16 | Priority register read data |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_level | output | 5 | Level of the presented request (0..16) |
| irq_src | output | SID_W | Source ID of the presented request |
| irq_vec | output | VEC_W | Vector number of the presented request |
| ack | input | 1 | Acknowledge pulse from the processor |
| mask_out | output | 4 | New mask value, loaded on acknowledge |

## Verification
The assertions assume that `ack` is a single-cycle pulse and is raised only while `irq_req` is high. They also assume `sr_mask` is the value the processor holds at the clock edge on which arbitration takes place. The stimulus drives every input on the falling edge. It raises `ack` for exactly one cycle, and only after it has seen the request. Each scenario drops its source requests in the same cycle as the acknowledge, so a retired request is never chosen again. The mask-comparison check takes the mask value from the cycle before the request rises, and the stimulus holds the mask constant across that edge.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int LVL_W  = 5;
    localparam int MASK_W = 4;

    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [MASK_W-1:0] mask_t;

    localparam level_t NMI_LEVEL = 5'd16;
    localparam level_t DBG_LEVEL = 5'd15;
    localparam mask_t  NMI_MASK  = 4'hF;

    localparam int SID_NMI   = 0;
    localparam int SID_DBG   = 1;
    localparam int SID_PROG0 = 2;
endpackage

// File: rtl/prio_regfile.sv
module prio_regfile #(
    parameter int NUM_SRC = 8,
    parameter int NUM_REG = (NUM_SRC + 3) / 4,
    parameter int ADDR_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [15:0]            wdata,
    output logic [15:0]            rdata,
    output logic [NUM_SRC-1:0][3:0] levels
);
    logic [NUM_REG-1:0][15:0] regs_d, regs_q;

    // next-state: a single register may be overwritten per cycle
    always_comb begin
        regs_d = regs_q;
        if (we && (int'(addr) < NUM_REG)) begin
            regs_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) < NUM_REG) rdata = regs_q[addr];
    end

    // four 4-bit level fields per register, source 4k+j in field j of register k
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
        assign levels[i] = regs_q[i / 4][4 * (i % 4) +: 4];
    end
endmodule

// File: rtl/prio_select.sv
module prio_select
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int SID_W   = $clog2(NUM_SRC + 2),
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0][3:0] levels,
    input  logic [NUM_SRC-1:0]      src_req,
    input  logic                    dbg_req,
    input  logic                    nmi_pend,
    input  mask_t                   sr_mask,
    output logic                    win_valid,
    output level_t                  win_level,
    output logic [SID_W-1:0]        win_sid
);
    level_t             best_lvl;
    logic [IDX_W-1:0]   best_idx;

    // ascending scan with strict compare: lowest index keeps a tie,
    // and a level-0 source can never replace the zero seed
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_req[i] && ({1'b0, levels[i]} > best_lvl)) begin
                best_lvl = {1'b0, levels[i]};
                best_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (nmi_pend) begin
            win_valid = 1'b1;
            win_level = NMI_LEVEL;
            win_sid   = SID_W'(SID_NMI);
        end else if (dbg_req) begin
            win_valid = DBG_LEVEL > {1'b0, sr_mask};
            win_level = DBG_LEVEL;
            win_sid   = SID_W'(SID_DBG);
        end else begin
            win_valid = best_lvl > {1'b0, sr_mask};
            win_level = best_lvl;
            win_sid   = SID_W'(SID_PROG0) + SID_W'(best_idx);
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_NMI  = 11,
    parameter int VEC_DBG  = 12,
    parameter int NUM_REG  = (NUM_SRC + 3) / 4,
    parameter int ADDR_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1,
    parameter int SID_W    = $clog2(NUM_SRC + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_in,
    input  logic               dbg_req,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [3:0]         sr_mask,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    output logic               irq_req,
    output logic [4:0]         irq_level,
    output logic [SID_W-1:0]   irq_src,
    output logic [VEC_W-1:0]   irq_vec,
    input  logic               ack,
    output logic [3:0]         mask_out
);
    localparam logic [SID_W-1:0] SID_NMI_L   = SID_W'(SID_NMI);
    localparam logic [SID_W-1:0] SID_DBG_L   = SID_W'(SID_DBG);
    localparam logic [SID_W-1:0] SID_PROG0_L = SID_W'(SID_PROG0);

    typedef struct packed {
        logic               req;
        level_t             level;
        logic [SID_W-1:0]   sid;
        logic [VEC_W-1:0]   vec;
        mask_t              mask;
        logic               nmi_prev;
        logic               nmi_pend;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_SRC-1:0][3:0] levels;
    logic                    win_valid;
    level_t                  win_level;
    logic [SID_W-1:0]        win_sid;

    prio_regfile #(
        .NUM_SRC (NUM_SRC),
        .NUM_REG (NUM_REG),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .levels (levels)
    );

    prio_select #(
        .NUM_SRC (NUM_SRC),
        .SID_W   (SID_W)
    ) u_sel (
        .levels    (levels),
        .src_req   (src_req),
        .dbg_req   (dbg_req),
        .nmi_pend  (state_q.nmi_pend),
        .sr_mask   (sr_mask),
        .win_valid (win_valid),
        .win_level (win_level),
        .win_sid   (win_sid)
    );

    always_comb begin
        logic nmi_rise;
        logic nmi_clr;
        state_d  = state_q;
        nmi_rise = nmi_in & ~state_q.nmi_prev;
        nmi_clr  = 1'b0;
        state_d.nmi_prev = nmi_in;

        if (state_q.req) begin
            if (ack) begin
                state_d.req = 1'b0;
                if (state_q.sid == SID_NMI_L) begin
                    state_d.mask = NMI_MASK;
                    nmi_clr      = 1'b1;
                end else begin
                    state_d.mask = state_q.level[3:0];
                end
            end
        end else if (win_valid) begin
            state_d.req   = 1'b1;
            state_d.level = win_level;
            state_d.sid   = win_sid;
            if (win_sid == SID_NMI_L)      state_d.vec = VEC_W'(VEC_NMI);
            else if (win_sid == SID_DBG_L) state_d.vec = VEC_W'(VEC_DBG);
            else state_d.vec = VEC_W'(VEC_BASE) + VEC_W'(win_sid - SID_PROG0_L);
        end

        state_d.nmi_pend = (state_q.nmi_pend & ~nmi_clr) | nmi_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.mask <= 4'hF;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_req   = state_q.req;
    assign irq_level = state_q.level;
    assign irq_src   = state_q.sid;
    assign irq_vec   = state_q.vec;
    assign mask_out  = state_q.mask;

    // R7: presented request frozen until acknowledged
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ack) |=> (irq_req && $stable(irq_level) && $stable(irq_src) && $stable(irq_vec)));

    // R8: acknowledge retires the request on the next clock
    a_r8_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack) |=> !irq_req);

    // R8: mask loads the accepted maskable level
    a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack && irq_src != SID_NMI_L) |=> (mask_out == $past(irq_level[3:0])));

    // R8: mask changes only on an acknowledge
    a_r8_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_req && ack) |=> $stable(mask_out));

    // R6: non-maskable request carries level 16 and loads 4'hF
    a_r6_nmi_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_src == SID_NMI_L) |-> (irq_level == 5'd16));
    a_r6_nmi_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack && irq_src == SID_NMI_L) |=> (mask_out == 4'hF));

    // R5: debug request always at level 15
    a_r5_dbg_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_src == SID_DBG_L) |-> (irq_level == 5'd15));

    // R3: a newly raised maskable request beat the mask it was compared to
    a_r3_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req) && irq_src != SID_NMI_L) |-> (irq_level > {1'b0, $past(sr_mask)}));
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
    localparam int NSRC  = 8;
    localparam int VBASE = 64;
    localparam int VNMI  = 11;
    localparam int VDBG  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              nmi_in = 1'b0;
    logic              dbg_req = 1'b0;
    logic [NSRC-1:0]   src_req = '0;
    logic [3:0]        sr_mask = 4'h0;
    logic              reg_we = 1'b0;
    logic [0:0]        reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              irq_req;
    logic [4:0]        irq_level;
    logic [3:0]        irq_src;
    logic [7:0]        irq_vec;
    logic              ack = 1'b0;
    logic [3:0]        mask_out;

    int checks = 0;
    int errors = 0;
    int lvl [NSRC];

    always #5 clk = ~clk;

    prio_intc uut (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .dbg_req(dbg_req),
        .src_req(src_req), .sr_mask(sr_mask), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_level(irq_level), .irq_src(irq_src),
        .irq_vec(irq_vec), .ack(ack), .mask_out(mask_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_reg(input int a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = 1'(a); reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic set_level(input int s, input int l);
        logic [15:0] w;
        lvl[s] = l;
        w = '0;
        for (int j = 0; j < 4; j++) w[4*j +: 4] = 4'(lvl[(s/4)*4 + j]);
        write_reg(s / 4, w);
    endtask

    // presented request: check fields, acknowledge, check retirement and mask
    task automatic take(input string tag, input int elvl, input int esid, input int evec, input int emask);
        chk(irq_req == 1'b1, {tag, " req"}, int'(irq_req), 1);
        chk(int'(irq_level) == elvl, {tag, " level"}, int'(irq_level), elvl);
        chk(int'(irq_src) == esid, {tag, " src"}, int'(irq_src), esid);
        chk(int'(irq_vec) == evec, {tag, " vec"}, int'(irq_vec), evec);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        src_req = '0;
        dbg_req = 1'b0;
        chk(irq_req == 1'b0, "R8 drop after ack", int'(irq_req), 0);
        chk(int'(mask_out) == emask, "R8 mask load", int'(mask_out), emask);
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSRC; i++) lvl[i] = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk(irq_req == 1'b0, "R1 req after reset", int'(irq_req), 0);
        chk(mask_out == 4'hF, "R1 mask after reset", int'(mask_out), 15);
        for (int a = 0; a < 2; a++) begin
            reg_addr = 1'(a); #1;
            chk(reg_rdata == 16'h0, "R1 reg reset", int'(reg_rdata), 0);
        end

        // R2: register readback and field-to-source mapping
        write_reg(0, 16'hA5C3);
        write_reg(1, 16'h1F0E);
        reg_addr = 1'b0; #1;
        chk(reg_rdata == 16'hA5C3, "R2 readback reg0", int'(reg_rdata), 'hA5C3);
        reg_addr = 1'b1; #1;
        chk(reg_rdata == 16'h1F0E, "R2 readback reg1", int'(reg_rdata), 'h1F0E);
        tick();
        sr_mask = 4'd14; src_req = 8'h40;            // source 6 = reg1 field 2 = 15
        tick();
        take("R2 field map src6", 15, 8, VBASE + 6, 15);
        sr_mask = 4'd0; src_req = 8'h20;             // source 5 = reg1 field 1 = 0
        tick();
        chk(irq_req == 1'b0, "R2 field map src5 zero", int'(irq_req), 0);
        src_req = '0;
        write_reg(0, 16'h0);
        write_reg(1, 16'h0);
        tick();

        // R3 R9: every source x every level x every mask
        for (int s = 0; s < NSRC; s++) begin
            for (int l = 0; l < 16; l++) begin
                set_level(s, l);
                for (int m = 0; m < 16; m++) begin
                    sr_mask = 4'(m);
                    src_req = NSRC'(1) << s;
                    tick();
                    if (l > m) begin
                        take("R3 R9 sweep", l, 2 + s, VBASE + s, l);
                    end else begin
                        chk(irq_req == 1'b0, "R3 masked", int'(irq_req), 0);
                        src_req = '0;
                        tick();
                    end
                end
            end
            set_level(s, 0);
        end

        // R4: pairwise contention, including equal levels
        sr_mask = 4'd0;
        for (int a = 0; a < NSRC; a++) begin
            for (int b = a + 1; b < NSRC; b++) begin
                for (int ia = 0; ia < 3; ia++) begin
                    for (int ib = 0; ib < 3; ib++) begin
                        int la;
                        int lb;
                        la = (ia == 0) ? 0 : (ia == 1) ? 7 : 15;
                        lb = (ib == 0) ? 0 : (ib == 1) ? 7 : 15;
                        set_level(a, la);
                        set_level(b, lb);
                        src_req = (NSRC'(1) << a) | (NSRC'(1) << b);
                        tick();
                        if (la == 0 && lb == 0) begin
                            chk(irq_req == 1'b0, "R4 both zero", int'(irq_req), 0);
                            src_req = '0;
                            tick();
                        end else if (la >= lb) begin
                            take("R4 lower index or higher level", la, 2 + a, VBASE + a, la);
                        end else begin
                            take("R4 higher level", lb, 2 + b, VBASE + b, lb);
                        end
                    end
                end
                set_level(a, 0);
                set_level(b, 0);
            end
        end

        // R5: debug source
        set_level(3, 15);
        sr_mask = 4'd14; src_req = 8'h08; dbg_req = 1'b1;
        tick();
        take("R5 debug beats level 15", 15, 1, VDBG, 15);
        sr_mask = 4'd15; dbg_req = 1'b1;
        tick(); tick();
        chk(irq_req == 1'b0, "R5 debug masked at 15", int'(irq_req), 0);
        dbg_req = 1'b0;
        tick();

        // R6 R7: non-maskable over masked sources, hold without ack
        src_req = 8'h08; dbg_req = 1'b1; sr_mask = 4'd15;
        nmi_in = 1'b1;
        tick(); tick();
        chk(irq_req == 1'b1, "R6 nmi presented under full mask", int'(irq_req), 1);
        sr_mask = 4'd0; src_req = 8'hFF; dbg_req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk(irq_src == 4'd0, "R7 src held", int'(irq_src), 0);
            chk(irq_level == 5'd16, "R7 level held", int'(irq_level), 16);
        end
        sr_mask = 4'd15;
        take("R6 nmi accept", 16, 0, VNMI, 15);
        for (int k = 0; k < 4; k++) tick();
        chk(irq_req == 1'b0, "R6 steady high no retrigger", int'(irq_req), 0);
        nmi_in = 1'b0;
        tick();
        nmi_in = 1'b1;
        tick(); tick();
        take("R6 second edge", 16, 0, VNMI, 15);
        nmi_in = 1'b0;
        set_level(3, 0);
        tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule